// File: doc/BRIEF.md
# Debug Interrupt and Emulator-Mode Controller

This block sits next to a processor core's exception logic and decides what happens when a breakpoint fires. A two-bit response setting picks one of three reactions to a trigger. The trigger can be shown on the debug status bus only, it can request a halt for background debug, or it can raise a debug interrupt. A debug interrupt can also be requested from an external pin. A pending debug interrupt outranks every normal interrupt.

Entering the debug handler sets a hidden emulator-mode flag. When mapping is enabled, this flag steers all instruction and operand accesses to a separate address space. The block hands the core the current flag value to write into every exception frame. On return-from-exception the block reloads the flag from the frame. Because of this, normal and nested interrupts can run inside the debug handler, and the interrupt mask is never changed for a debug entry.

After a return that leaves the handler, debug interrupts are held off for one instruction completion. A read-only revision output identifies the feature level.

Top module: `dbg_emu_ctrl`

## Requirements
- R1: `resp_mode_i` encodes the response to a trigger: 00 display only, 01 halt, 10 debug interrupt, 11 treated as display only. In halt mode a trigger gives a one-cycle `halt_req_o` pulse in the cycle after the trigger.
- R2: In the cycle after a trigger, `ddata_o` shows the status code 4'b1001 (display), 4'b1010 (halt) or 4'b1011 (debug interrupt). In every other cycle it shows 4'b0000.
- R3: A trigger in debug-interrupt mode, or `ext_dbg_req_i` high, makes a debug request pending. `dbg_irq_o` is high from the next cycle until a debug exception entry.
- R4: While `dbg_irq_o` is high, `irq_ok_o` is low, whatever the normal interrupt level is.
- R5: `pst_o` is 4'b1101 in the cycle after a debug entry and 4'b1100 in the cycle after a normal entry. Otherwise it is 4'b0000.
- R6: A debug entry sets the emulator flag `emu_o`. `map_emu_o` is high exactly when `emu_o` and `map_en_i` are both high.
- R7: On a normal entry `mask_wr_o` is high and `mask_val_o` equals `irq_level_i`. On a debug entry `mask_wr_o` stays low.
- R8: `frame_emu_o` equals the flag at the moment of entry. A normal entry clears the flag. `rte_i` reloads the flag from `frame_emu_i` in the next cycle.
- R9: An `rte_i` that clears a set flag blocks `dbg_irq_o` until the next `insn_done_i` after it. A request arriving in that window stays pending and appears once the window closes.
- R10: `irq_ok_o` is high only for a non-zero level that is above `mask_level_i` or equal to 7, with no debug request shown.
- R11: `rev_o` always shows the `REV_CODE` parameter (default 4'h3).
- R12: After reset, `emu_o`, `dbg_irq_o`, `halt_req_o`, `ddata_o` and `pst_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| bkpt_trig_i | input | 1 | Breakpoint trigger pulse |
| resp_mode_i | input | 2 | Trigger response selection |
| ext_dbg_req_i | input | 1 | External debug interrupt request |
| irq_level_i | input | 3 | Pending normal interrupt level, 0 = none |
| mask_level_i | input | 3 | Current interrupt mask |
| map_en_i | input | 1 | Enables emulator address mapping |
| exc_entry_i | input | 1 | Core enters an exception this cycle |
| entry_is_dbg_i | input | 1 | The entry is the debug interrupt |
| rte_i | input | 1 | Return-from-exception executes |
| frame_emu_i | input | 1 | Emulator bit read from the frame |
| insn_done_i | input | 1 | Instruction completion |
| halt_req_o | output | 1 | Halt request pulse |
| dbg_irq_o | output | 1 | Debug interrupt request to core |
| irq_ok_o | output | 1 | Normal interrupt may be taken |
| mask_wr_o | output | 1 | Load mask on this entry |
| mask_val_o | output | 3 | Value for the mask load |
| ddata_o | output | 4 | Trigger status code |
| pst_o | output | 4 | Processor status code |
| emu_o | output | 1 | Emulator-mode flag |
| map_emu_o | output | 1 | Redirect accesses to emulator space |
| frame_emu_o | output | 1 | Emulator bit to store in the frame |
| rev_o | output | 4 | Revision code |

## Verification
A wrong emulator flag shows up in the cycle after the entry or return that set it. It appears on `emu_o` and `map_emu_o`, and at the next entry on `frame_emu_o`. A lost or stuck pending request shows on `dbg_irq_o` one cycle after the event, and also as a wrong `irq_ok_o` for a level-7 request. A hold-off window that is too long or too short shows as `dbg_irq_o` rising too early or not at all after the next instruction completion.

// File: rtl/dbg_emu_pkg.sv
package dbg_emu_pkg;
    typedef enum logic [1:0] {
        RESP_SHOW  = 2'b00,
        RESP_HALT  = 2'b01,
        RESP_DBG   = 2'b10,
        RESP_RSVD  = 2'b11
    } resp_e;

    typedef logic [3:0] pst_t;
    localparam pst_t PST_RUN   = 4'b0000;
    localparam pst_t PST_EXC   = 4'b1100;
    localparam pst_t PST_DBG   = 4'b1101;
endpackage

// File: rtl/dbg_resp_decode.sv
module dbg_resp_decode
    import dbg_emu_pkg::*;
#(
    parameter int DD_W = 4
) (
    input  logic            trig_i,
    input  logic [1:0]      mode_i,
    output logic            halt_set_o,
    output logic            dbg_set_o,
    output logic [DD_W-1:0] code_o
);
    localparam int PAD_W = DD_W - 3;

    resp_e      mode;
    logic [1:0] sel;

    always_comb begin
        mode       = resp_e'(mode_i);
        halt_set_o = 1'b0;
        dbg_set_o  = 1'b0;
        sel        = 2'b01;
        case (mode)
            RESP_HALT: begin
                halt_set_o = trig_i;
                sel        = 2'b10;
            end
            RESP_DBG: begin
                dbg_set_o  = trig_i;
                sel        = 2'b11;
            end
            default: sel = 2'b01;
        endcase
        code_o = trig_i ? {1'b1, {PAD_W{1'b0}}, sel} : '0;
    end
endmodule

// File: rtl/dbg_pend_ctrl.sv
module dbg_pend_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    input  logic leave_i,
    input  logic insn_done_i,
    output logic req_o
);
    typedef struct packed {
        logic pend;
        logic hold;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
        if (leave_i)
            st_d.hold = 1'b1;
        else if (insn_done_i)
            st_d.hold = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign req_o = st_q.pend & ~st_q.hold;

    AST_HOLD_AFTER_LEAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        leave_i |=> !req_o); // R9
    AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i && !leave_i && !insn_done_i |=> st_q.pend); // R3
endmodule

// File: rtl/dbg_irq_arb.sv
module dbg_irq_arb #(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             dbg_req_i,
    input  logic             entry_i,
    input  logic             entry_dbg_i,
    output logic             ok_o,
    output logic             mask_wr_o,
    output logic [LVL_W-1:0] mask_val_o
);
    localparam logic [LVL_W-1:0] NMI_LVL = {LVL_W{1'b1}};

    logic above;

    always_comb begin
        above      = (level_i != '0) && ((level_i > mask_i) || (level_i == NMI_LVL));
        ok_o       = above && !dbg_req_i;
        mask_wr_o  = entry_i && !entry_dbg_i;
        mask_val_o = level_i;
    end
endmodule

// File: rtl/dbg_emu_ctrl.sv
module dbg_emu_ctrl
    import dbg_emu_pkg::*;
#(
    parameter int               LVL_W    = 3,
    parameter int               DD_W     = 4,
    parameter int               REV_W    = 4,
    parameter logic [REV_W-1:0] REV_CODE = 4'h3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bkpt_trig_i,
    input  logic [1:0]       resp_mode_i,
    input  logic             ext_dbg_req_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [LVL_W-1:0] mask_level_i,
    input  logic             map_en_i,
    input  logic             exc_entry_i,
    input  logic             entry_is_dbg_i,
    input  logic             rte_i,
    input  logic             frame_emu_i,
    input  logic             insn_done_i,
    output logic             halt_req_o,
    output logic             dbg_irq_o,
    output logic             irq_ok_o,
    output logic             mask_wr_o,
    output logic [LVL_W-1:0] mask_val_o,
    output logic [DD_W-1:0]  ddata_o,
    output pst_t             pst_o,
    output logic             emu_o,
    output logic             map_emu_o,
    output logic             frame_emu_o,
    output logic [REV_W-1:0] rev_o
);
    typedef struct packed {
        logic            emu;
        logic            halt;
        logic [DD_W-1:0] ddata;
        pst_t            pst;
    } top_st_t;

    top_st_t         st_d, st_q;
    logic            halt_set, dbg_set, dbg_clr, leave;
    logic [DD_W-1:0] code;

    dbg_resp_decode #(.DD_W(DD_W)) dec_i (
        .trig_i     (bkpt_trig_i),
        .mode_i     (resp_mode_i),
        .halt_set_o (halt_set),
        .dbg_set_o  (dbg_set),
        .code_o     (code)
    );

    assign dbg_clr = exc_entry_i & entry_is_dbg_i;
    assign leave   = rte_i & st_q.emu & ~frame_emu_i & ~exc_entry_i;

    dbg_pend_ctrl pend_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_i       (dbg_set | ext_dbg_req_i),
        .clr_i       (dbg_clr),
        .leave_i     (leave),
        .insn_done_i (insn_done_i),
        .req_o       (dbg_irq_o)
    );

    dbg_irq_arb #(.LVL_W(LVL_W)) arb_i (
        .level_i     (irq_level_i),
        .mask_i      (mask_level_i),
        .dbg_req_i   (dbg_irq_o),
        .entry_i     (exc_entry_i),
        .entry_dbg_i (entry_is_dbg_i),
        .ok_o        (irq_ok_o),
        .mask_wr_o   (mask_wr_o),
        .mask_val_o  (mask_val_o)
    );

    always_comb begin
        st_d       = st_q;
        st_d.halt  = halt_set;
        st_d.ddata = code;
        st_d.pst   = PST_RUN;
        if (exc_entry_i) begin
            st_d.emu = entry_is_dbg_i;
            st_d.pst = entry_is_dbg_i ? PST_DBG : PST_EXC;
        end else if (rte_i) begin
            st_d.emu = frame_emu_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign halt_req_o  = st_q.halt;
    assign ddata_o     = st_q.ddata;
    assign pst_o       = st_q.pst;
    assign emu_o       = st_q.emu;
    assign frame_emu_o = st_q.emu;
    assign map_emu_o   = st_q.emu & map_en_i;
    assign rev_o       = REV_CODE;

    AST_HALT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bkpt_trig_i && resp_mode_i == 2'b01 |=> halt_req_o); // R1
    AST_TRIG_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bkpt_trig_i |=> ddata_o[DD_W-1]); // R2
    AST_DBG_OUTRANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_irq_o |-> !irq_ok_o); // R4
    AST_DBG_PST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_entry_i && entry_is_dbg_i |=> pst_o == PST_DBG && emu_o); // R5
    AST_NO_MASK_ON_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_entry_i && entry_is_dbg_i |-> !mask_wr_o); // R7
    AST_EMU_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rte_i && !exc_entry_i |=> emu_o == $past(frame_emu_i)); // R8
endmodule

// File: tb/dbg_emu_ctrl_tb.sv
module dbg_emu_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 0, ext = 0, map_en = 0, entry = 0, entry_dbg = 0;
    logic       rte = 0, frame_in = 0, done = 0;
    logic [1:0] mode = 0;
    logic [2:0] lvl = 0, mask = 0;
    logic       halt, dbg, ok, mwr, emu, map_emu, frame_out;
    logic [2:0] mval;
    logic [3:0] dd, pst, rev;
    int         errors = 0, checks = 0;
    bit         finished = 0;

    always #10 clk = ~clk;

    dbg_emu_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bkpt_trig_i(trig), .resp_mode_i(mode),
        .ext_dbg_req_i(ext), .irq_level_i(lvl), .mask_level_i(mask),
        .map_en_i(map_en), .exc_entry_i(entry), .entry_is_dbg_i(entry_dbg),
        .rte_i(rte), .frame_emu_i(frame_in), .insn_done_i(done),
        .halt_req_o(halt), .dbg_irq_o(dbg), .irq_ok_o(ok), .mask_wr_o(mwr),
        .mask_val_o(mval), .ddata_o(dd), .pst_o(pst), .emu_o(emu),
        .map_emu_o(map_emu), .frame_emu_o(frame_out), .rev_o(rev)
    );

    // {trig, mode[1:0], ddata[3:0], halt, dbg}
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 2'b10, 4'b0000, 1'b0, 1'b0},
        {1'b1, 2'b00, 4'b1001, 1'b0, 1'b0},
        {1'b1, 2'b01, 4'b1010, 1'b1, 1'b0},
        {1'b1, 2'b10, 4'b1011, 1'b0, 1'b1},
        {1'b1, 2'b11, 4'b1001, 1'b0, 1'b0},
        {1'b0, 2'b01, 4'b0000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        trig = 0; ext = 0; entry = 0; entry_dbg = 0; rte = 0; done = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R12 reset state, R11 revision
        chk("R12 emu", emu, 0);
        chk("R12 dbg", dbg, 0);
        chk("R12 halt", halt, 0);
        chk("R12 ddata", dd, 0);
        chk("R12 pst", pst, 0);
        chk("R11 rev", rev, 4'h3);

        // R1 R2 R3 response table
        for (int i = 0; i < 6; i++) begin
            do_reset();
            trig = VEC[i][8]; mode = VEC[i][7:6];
            step();
            chk("R2 ddata", dd, VEC[i][5:2]);
            chk("R1 halt", halt, VEC[i][1]);
            chk("R3 dbg", dbg, VEC[i][0]);
            idle();
            step();
            chk("R1 halt one cycle", halt, 0);
            chk("R2 ddata clear", dd, 0);
        end

        // R3 external request, R4 priority over level 7
        do_reset();
        ext = 1;
        step();
        chk("R3 ext pending", dbg, 1);
        idle();
        lvl = 3'd7; mask = 3'd0;
        #1 chk("R4 dbg outranks nmi", ok, 0);
        step();
        chk("R3 pending kept", dbg, 1);

        // debug entry: R7 R5 R6
        @(negedge clk);
        entry = 1; entry_dbg = 1;
        #1 chk("R7 no mask write dbg", mwr, 0);
        step();
        chk("R5 pst dbg", pst, 4'b1101);
        chk("R6 emu set", emu, 1);
        chk("R3 cleared by entry", dbg, 0);
        idle();
        map_en = 1;
        #1 chk("R6 map on", map_emu, 1);
        map_en = 0;
        #1 chk("R6 map off", map_emu, 0);
        chk("R4 nmi ok now", ok, 1);
        step();
        chk("R5 pst back", pst, 0);

        // R10 acceptance inside handler
        lvl = 3'd3; mask = 3'd5;
        #1 chk("R10 below mask", ok, 0);
        lvl = 3'd6;
        #1 chk("R10 above mask", ok, 1);
        lvl = 3'd7; mask = 3'd7;
        #1 chk("R10 nmi at mask 7", ok, 1);
        lvl = 3'd0; mask = 3'd0;
        #1 chk("R10 level zero", ok, 0);
        lvl = 3'd6; mask = 3'd5;

        // nested normal entry R7 R8 R5
        @(negedge clk);
        entry = 1; entry_dbg = 0;
        #1 chk("R7 mask write", mwr, 1);
        chk("R7 mask value", mval, 6);
        chk("R8 frame bit", frame_out, 1);
        step();
        chk("R8 normal entry clears", emu, 0);
        chk("R5 pst exc", pst, 4'b1100);
        idle();
        rte = 1; frame_in = 1;
        step();
        chk("R8 restored set", emu, 1);

        // leave handler, hold-off R9
        idle();
        rte = 1; frame_in = 0;
        step();
        chk("R8 restored clear", emu, 0);
        idle();
        ext = 1;
        step();
        chk("R9 held off", dbg, 0);
        idle();
        step();
        chk("R9 still held", dbg, 0);
        idle();
        done = 1;
        step();
        chk("R9 released", dbg, 1);
        idle();
        finish_run();
    end
endmodule